// File: doc/BRIEF.md
# Host Watchdog and Reset Supervisor

This block watches over a host controller. The host is expected to toggle a clock-like watchdog line, and the block gives the host an active-low reset. When the supply reports good, the block holds the host in reset for a fixed number of time-base ticks. It then releases the host and opens a startup window, in which the host's watchdog line must show its first rising edge. After that first edge the block runs a timeout that restarts on every rising edge. If the line stops, the timeout expires and this is treated as an oscillation stop.

Either kind of watchdog fault sets a sticky fault flag. While the flag is set, the charge, discharge and precharge FET drives are forced to their off levels. The fault also pulses the host reset for one full reset period, after which supervision starts again at the startup window. The flag stays set even after the host recovers. Only a latch-clear toggle clears it: the clear line is raised and then lowered. A drop of power-good asserts the host reset at once. The sleep input does not pause supervision. All time spans are counted in pulses of a periodic tick input. There is no data stream, so every pin is a plain control or status pin.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst_n` is low, and after reset with `pwr_good` low, `host_rst_n` is 0 and `wd_fault` is 0. The drives are at their off levels: `chg_drv`=0, `dsg_drv`=0 and `pre_drv`=`PRE_OFF_LVL` (default 1).
- R2: After `pwr_good` goes high, `host_rst_n` stays 0 until `RST_TICKS` tick pulses have been counted. It goes to 1 in the cycle after the clock edge that samples the last of those ticks.
- R3: When `pwr_good` is 0, `host_rst_n` is 0 in the same cycle through a combinational path. The reset-period count restarts from zero, and no fault is raised.
- R4: After reset release, the startup window begins. If `START_TICKS` ticks pass with no rising watchdog edge, `wd_fault` becomes 1 and `host_rst_n` becomes 0, both in the cycle after the edge that samples the last tick. The host reset then lasts `RST_TICKS` ticks, after which a new startup window begins.
- R5: Once a rising watchdog edge has been seen, the running timeout restarts on every rising edge. If `RUN_TICKS` ticks pass with no rising edge, the block faults in the same way as in R4.
- R6: `wd_fault` stays 1 through further watchdog activity and host recovery. It clears on the clock edge that samples `latch_clr` low after having sampled it high in the previous cycle.
- R7: If a fault event and a latch-clear falling edge occur in the same cycle, the fault wins and `wd_fault` stays 1.
- R8: `wdi` passes through a two-flop synchronizer, and only rising edges are counted. A synchronized rising edge that comes in the same cycle as the final tick of a window restarts the window instead of faulting. Edges during the reset period are ignored.
- R9: `sleep_req` has no effect on supervision, on `host_rst_n` or on `wd_fault`.
- R10: When `pwr_good` is 1 and `wd_fault` is 0, each drive equals its request (`chg_req`, `dsg_req`, `pre_req`). Otherwise each drive is at its off level as given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pwr_good | input | 1 | Supply-good indication, active high |
| tick | input | 1 | One-cycle time-base pulse that all windows count |
| wdi | input | 1 | Asynchronous watchdog toggle line from the host |
| sleep_req | input | 1 | Sleep-mode indication; does not pause supervision |
| latch_clr | input | 1 | Latch-clear line; a high-then-low toggle clears the fault flag |
| chg_req | input | 1 | Requested charge FET drive |
| dsg_req | input | 1 | Requested discharge FET drive |
| pre_req | input | 1 | Requested precharge FET drive |
| host_rst_n | output | 1 | Active-low reset to the host |
| wd_fault | output | 1 | Sticky watchdog fault flag |
| chg_drv | output | 1 | Charge FET drive; off level 0 |
| dsg_drv | output | 1 | Discharge FET drive; off level 0 |
| pre_drv | output | 1 | Precharge FET drive; off level `PRE_OFF_LVL` |

## Verification
Two pairs of events can fall in the same cycle. In the first, a fault event and a latch-clear falling edge land together. In the second, a synchronized rising watchdog edge arrives on the final tick of a window. The bench sweeps the gap between watchdog edges across the running timeout, and it moves latch-clear pulses through that sweep, so both coincidences occur at many offsets. A behavioural reference model compares every output on every cycle and judges each case: the fault must win over the clear, and the edge must win over the expiry.

// File: rtl/wds_pkg.sv
package wds_pkg;
  typedef enum logic [1:0] {
    PH_HOLD  = 2'd0,
    PH_START = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;
endpackage

// File: rtl/wds_edge_sync.sv
module wds_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh[0] <= 1'b0;
    else        sh[0] <= async_in;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh[g] <= 1'b0;
      else        sh[g] <= sh[g-1];
    end
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];

  a_r8_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/wds_phase_timer.sv
module wds_phase_timer
  import wds_pkg::*;
#(
  parameter int RST_TICKS   = 4,
  parameter int START_TICKS = 8,
  parameter int RUN_TICKS   = 5
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pwr_good,
  input  logic   tick,
  input  logic   rise,
  output phase_t phase_o,
  output logic   fault_o
);
  localparam int MAXT  = (RST_TICKS > START_TICKS) ?
                         ((RST_TICKS > RUN_TICKS) ? RST_TICKS : RUN_TICKS) :
                         ((START_TICKS > RUN_TICKS) ? START_TICKS : RUN_TICKS);
  localparam int CNT_W = (MAXT < 2) ? 1 : $clog2(MAXT + 1);
  localparam logic [CNT_W-1:0] RST_LAST   = CNT_W'(RST_TICKS - 1);
  localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_TICKS - 1);
  localparam logic [CNT_W-1:0] RUN_LAST   = CNT_W'(RUN_TICKS - 1);

  phase_t           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flt;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    flt   = 1'b0;
    if (!pwr_good) begin
      ph_d  = PH_HOLD;
      cnt_d = '0;
    end else begin
      unique case (ph_q)
        PH_HOLD: begin
          if (tick) begin
            if (cnt_q == RST_LAST) begin
              ph_d  = PH_START;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        PH_START: begin
          if (rise) begin
            ph_d  = PH_RUN;
            cnt_d = '0;
          end else if (tick) begin
            if (cnt_q == START_LAST) begin
              flt   = 1'b1;
              ph_d  = PH_HOLD;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        PH_RUN: begin
          if (rise) begin
            cnt_d = '0;
          end else if (tick) begin
            if (cnt_q == RUN_LAST) begin
              flt   = 1'b1;
              ph_d  = PH_HOLD;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: begin
          ph_d  = PH_HOLD;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_HOLD;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase_o = ph_q;
  assign fault_o = flt;

  a_r3_pg_low_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (ph_q == PH_HOLD && cnt_q == '0));
  a_r4_fault_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> (ph_q == PH_HOLD));
  a_r8_rise_restarts_run: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && rise && ph_q != PH_HOLD) |=> (ph_q == PH_RUN && cnt_q == '0));
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAXT));
endmodule

// File: rtl/wds_fault_latch.sv
module wds_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_lvl_i,
  output logic flag_o
);
  logic clr_prev;
  logic clr_fall;

  assign clr_fall = clr_prev & ~clr_lvl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_prev <= 1'b0;
      flag_o   <= 1'b0;
    end else begin
      clr_prev <= clr_lvl_i;
      if (set_i)         flag_o <= 1'b1;
      else if (clr_fall) flag_o <= 1'b0;
    end
  end

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !(clr_prev && !clr_lvl_i)) |=> flag_o);
endmodule

// File: rtl/wds_fet_gate.sv
module wds_fet_gate #(
  parameter int           N       = 3,
  parameter logic [N-1:0] OFF_LVL = '0
) (
  input  logic         force_off,
  input  logic [N-1:0] req,
  output logic [N-1:0] drv
);
  for (genvar g = 0; g < N; g++) begin : g_fet
    assign drv[g] = force_off ? OFF_LVL[g] : req[g];
  end
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wds_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter int   RST_TICKS   = 4,
  parameter int   START_TICKS = 8,
  parameter int   RUN_TICKS   = 5,
  parameter logic PRE_OFF_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic tick,
  input  logic wdi,
  input  logic sleep_req,
  input  logic latch_clr,
  input  logic chg_req,
  input  logic dsg_req,
  input  logic pre_req,
  output logic host_rst_n,
  output logic wd_fault,
  output logic chg_drv,
  output logic dsg_drv,
  output logic pre_drv
);
  localparam int NFET = 3;
  localparam logic [NFET-1:0] FET_OFF = {PRE_OFF_LVL, 1'b0, 1'b0};

  logic   rise;
  logic   fault_evt;
  phase_t phase;
  logic   flag;
  logic [NFET-1:0] drv;
  logic   sleep_unused;

  // Supervision deliberately ignores sleep mode.
  assign sleep_unused = sleep_req;

  wds_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(wdi), .rise_o(rise)
  );

  wds_phase_timer #(
    .RST_TICKS(RST_TICKS), .START_TICKS(START_TICKS), .RUN_TICKS(RUN_TICKS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .tick(tick),
    .rise(rise), .phase_o(phase), .fault_o(fault_evt)
  );

  wds_fault_latch u_latch (
    .clk(clk), .rst_n(rst_n), .set_i(fault_evt), .clr_lvl_i(latch_clr),
    .flag_o(flag)
  );

  wds_fet_gate #(.N(NFET), .OFF_LVL(FET_OFF)) u_gate (
    .force_off(flag | ~pwr_good),
    .req({pre_req, dsg_req, chg_req}),
    .drv(drv)
  );

  assign host_rst_n = pwr_good & (phase != PH_HOLD);
  assign wd_fault   = flag;
  assign chg_drv    = drv[0];
  assign dsg_drv    = drv[1];
  assign pre_drv    = drv[2];

  a_r4_fault_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fault |-> (!chg_drv && !dsg_drv && pre_drv == PRE_OFF_LVL));
  a_r5_fault_resets_host: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (!host_rst_n && wd_fault));
endmodule

// File: tb/sim_wdog_supervisor.sv
module sim_wdog_supervisor;
  localparam int RST_T = 4, START_T = 8, RUN_T = 5;

  logic clk = 0, rst_n = 0, pwr_good = 0, tick = 0, wdi = 0, sleep_req = 0;
  logic latch_clr = 0, chg_req = 0, dsg_req = 0, pre_req = 0;
  logic host_rst_n, wd_fault, chg_drv, dsg_drv, pre_drv;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit started = 0, done = 0, tick_en = 0;
  int tdiv = 0;

  // reference model state
  int w1 = 0, w2 = 0, w3 = 0, mph = 0, mcnt = 0, mflag = 0, mlc = 0;

  always #5 clk = ~clk;

  wdog_supervisor #(.RST_TICKS(RST_T), .START_TICKS(START_T), .RUN_TICKS(RUN_T),
                    .PRE_OFF_LVL(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .tick(tick), .wdi(wdi),
    .sleep_req(sleep_req), .latch_clr(latch_clr), .chg_req(chg_req),
    .dsg_req(dsg_req), .pre_req(pre_req), .host_rst_n(host_rst_n),
    .wd_fault(wd_fault), .chg_drv(chg_drv), .dsg_drv(dsg_drv), .pre_drv(pre_drv));

  always @(posedge clk) begin
    int edge_s, flt, lim;
    started = 1;
    if (!rst_n) begin
      w1 = 0; w2 = 0; w3 = 0; mph = 0; mcnt = 0; mflag = 0; mlc = 0;
    end else begin
      edge_s = w2 & ~w3;
      flt = 0;
      if (!pwr_good) begin mph = 0; mcnt = 0; end
      else if (mph == 0) begin
        if (tick) begin
          if (mcnt == RST_T - 1) begin mph = 1; mcnt = 0; end else mcnt++;
        end
      end else begin
        lim = (mph == 1) ? START_T : RUN_T;
        if (edge_s) begin mph = 2; mcnt = 0; end
        else if (tick) begin
          if (mcnt == lim - 1) begin flt = 1; mph = 0; mcnt = 0; end else mcnt++;
        end
      end
      if (flt) mflag = 1;
      else if (mlc && !latch_clr) mflag = 0;
      mlc = latch_clr; w3 = w2; w2 = w1; w1 = wdi;
    end
  end

  // tick pulse every third cycle
  always @(posedge clk) begin
    #2;
    if (tick_en) begin tdiv = (tdiv + 1) % 3; tick = (tdiv == 0); end
    else tick = 0;
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", r, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic [4:0] e, a;
    logic off;
    if (started && !done) begin
      off = !pwr_good || (mflag != 0);
      e = {(pwr_good && mph != 0), (mflag != 0),
           off ? 1'b0 : chg_req, off ? 1'b0 : dsg_req, off ? 1'b1 : pre_req};
      a = {host_rst_n, wd_fault, chg_drv, dsg_drv, pre_drv};
      chk(cur_req, {27'd0, a}, {27'd0, e});
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic toggle_wdi(int half, int cycles);
    for (int i = 0; i < cycles; i++) begin
      if (i % half == 0) wdi = ~wdi;
      step(1);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    // R1 reset state
    step(3);
    @(negedge clk);
    chk("R1", {host_rst_n, wd_fault, chg_drv, dsg_drv, pre_drv}, 5'b00001);
    rst_n = 1; step(2);
    @(negedge clk);
    chk("R1", {host_rst_n, wd_fault, chg_drv, dsg_drv, pre_drv}, 5'b00001);
    // R2 power-up hold, then R5/R8 running with toggling host
    cur_req = "R2";
    step(1);
    chg_req = 1; dsg_req = 1; pre_req = 0;
    tick_en = 1; pwr_good = 1;
    step(2);
    @(negedge clk); chk("R2", host_rst_n, 0);
    step(20);
    cur_req = "R8";
    toggle_wdi(4, 200);
    @(negedge clk);
    chk("R10", {host_rst_n, wd_fault, chg_drv, dsg_drv, pre_drv}, 5'b10110);
    // R3 power drop
    cur_req = "R3";
    step(1); pwr_good = 0;
    @(negedge clk); chk("R3", host_rst_n, 0);
    chk("R10", {chg_drv, dsg_drv, pre_drv}, 3'b001);
    step(5); pwr_good = 1;
    // R4 startup window expiry, with sleep asserted (R9)
    cur_req = "R4"; sleep_req = 1;
    step(80);
    @(negedge clk);
    chk("R4", wd_fault, 1);
    chk("R9", {chg_drv, dsg_drv, pre_drv}, 3'b001);
    // R6 flag sticky after host recovery
    cur_req = "R6"; sleep_req = 0;
    step(1);
    toggle_wdi(3, 120);
    @(negedge clk); chk("R6", {host_rst_n, wd_fault}, 2'b11);
    step(1); latch_clr = 1; step(1); latch_clr = 0;
    toggle_wdi(3, 3);
    @(negedge clk); chk("R6", wd_fault, 0);
    // R5 running timeout: wdi parks high
    cur_req = "R5";
    step(1); wdi = 1; step(60);
    @(negedge clk); chk("R5", wd_fault, 1);
    // R8 falling-only activity does not feed the timer
    cur_req = "R8";
    step(1); latch_clr = 1; step(1); latch_clr = 0;
    toggle_wdi(2, 40);
    step(1); wdi = 1; step(10); wdi = 0; step(60);
    @(negedge clk); chk("R8", wd_fault, 1);
    // R7 / R8 coincidence sweep: edge gaps across the timeout, clears moving through
    cur_req = "R7";
    for (int gap = 8; gap < 26; gap++) begin
      for (int k = 0; k < 6; k++) begin
        wdi = 1; step(gap / 2); wdi = 0;
        if (k == gap % 6) begin latch_clr = 1; step(1); latch_clr = 0; step(gap - gap / 2 - 1); end
        else step(gap - gap / 2);
      end
      sleep_req = ~sleep_req;
    end
    // final clear and release
    step(1); latch_clr = 1; step(1); latch_clr = 0;
    toggle_wdi(3, 120);
    @(negedge clk); chk("R6", {host_rst_n, wd_fault}, 2'b10);
    finish_run();
  end
endmodule